// File: doc/BRIEF.md
# Matrix Keyboard and Sensor Scanner with Key FIFO

This block drives a 3-bit row select onto a key or sensor matrix and samples eight return lines for each row. It holds each row for a fixed number of clock cycles. The last cycle of that dwell is the sampling point. A host reads the results through a small read port, and an interrupt line tells the host when there is something to read.

In keyboard mode, a key is reported only after a debounce check. The key must be seen closed when its row is sampled, and still closed when the same row is sampled one full scan later. The block then packs the row, the column and the two modifier inputs into one byte and pushes that byte into an 8-entry FIFO. A held key is reported once. While a key is held, other keys are locked out. In sensor mode, the raw return-line pattern of each row is mirrored into an 8-row sensor RAM. A row is rewritten only when its pattern has changed, and the modifier inputs play no part.

Top module: `kms_top`

## Requirements
- R1: After reset, fifo_empty=1, fifo_full=0, overrun=0, irq=0 and scan_row=0.
- R2: scan_row steps 0,1,...,7,0 cyclically and holds each value for SCAN_DIV clock cycles (default 4). Return lines are sampled in the last cycle of each row's dwell.
- R3: A key code byte is laid out as bit 7 = ctrl_key, bit 6 = shift_key, bits 5:3 = row, bits 2:0 = column. Column n is return line n, and a line at 1 means closed. When several lines of a row are closed, the lowest-numbered one is taken.
- R4: A closure that is gone when its row is sampled one full scan later produces no code.
- R5: A key held over many scans produces exactly one code. Releasing it and pressing it again produces a second code.
- R6: Codes leave the FIFO in the order they entered. rd_data shows the popped code in the cycle after a cycle with rd_en=1 in keyboard mode (mode_sensor=0).
- R7: With 8 codes stored, fifo_full=1. A further valid closure is dropped, the stored codes are unchanged, and overrun goes to 1 and stays at 1 until reset.
- R8: rd_en while the FIFO is empty in keyboard mode leaves rd_data, fifo_empty and the FIFO contents unchanged.
- R9: In sensor mode (mode_sensor=1), sensor RAM row r holds the latest return-line pattern sampled at row r. Bit n of the row holds return line n. The row is read at rd_addr=r, and rd_data shows it in the cycle after rd_en. shift_key and ctrl_key do not affect the stored data, and nothing is pushed into the FIFO.
- R10: In keyboard mode, irq is 1 exactly while the FIFO holds at least one code.
- R11: In sensor mode, irq goes to 1 after any sensor RAM row changes and goes back to 0 on a host read. A pattern equal to the stored one does not raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sensor | input | 1 | 0 = keyboard mode, 1 = sensor mode |
| ret_lines | input | 8 | Return lines of the selected row, 1 = closed |
| shift_key | input | 1 | Shift modifier state |
| ctrl_key | input | 1 | Control modifier state |
| scan_row | output | 3 | Row currently driven onto the matrix |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Sensor RAM row to read (sensor mode) |
| rd_data | output | 8 | Registered read data |
| fifo_empty | output | 1 | FIFO holds no code |
| fifo_full | output | 1 | FIFO holds 8 codes |
| overrun | output | 1 | Sticky flag: a code was dropped on a full FIFO |
| irq | output | 1 | Interrupt to the host |

## Verification
The bench targets the following failure modes:

- **Bounce rejection.** A key is released before its row comes round again. A scanner that skips the confirmation scan would push a code here.
- **Held key.** A key is held for many scans. A scanner that does not lock the key would fill the FIFO with repeats.
- **Overflow.** A ninth closure arrives on a full FIFO. A FIFO with a wrong full test would either overwrite the oldest code or lose the flag.
- **Multiple columns.** Several columns of one row are closed together. A wrong priority encoder would report the wrong column.
- **Sensor interrupt.** An unchanged pattern is sampled again after a read. A design that writes the sensor RAM on every sample would re-raise the interrupt.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int ROW_W = 3;
  localparam int COL_W = 3;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_PEND = 2'd1,
    KS_HELD = 2'd2
  } key_state_t;

  typedef struct packed {
    logic             ctrl;
    logic             shift;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } key_code_t;
endpackage

// File: rtl/kms_scan_timer.sv
module kms_scan_timer #(
  parameter int ROWS     = 8,
  parameter int SCAN_DIV = 4,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int DIV_W   = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [ROW_W-1:0] row,
  output logic             sample
);
  logic [DIV_W-1:0] div_cnt;

  assign sample = (div_cnt == DIV_W'(SCAN_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      row     <= '0;
    end else if (sample) begin
      div_cnt <= '0;
      row     <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kms_key_debounce.sv
module kms_key_debounce
  import kms_pkg::*;
#(
  parameter int COLS   = 8,
  localparam int CW    = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sample,
  input  logic [ROW_W-1:0] row,
  input  logic [COLS-1:0]  ret,
  input  logic             shift_key,
  input  logic             ctrl_key,
  output logic             push,
  output key_code_t        code
);
  key_state_t       state;
  logic [ROW_W-1:0] cand_row;
  logic [CW-1:0]    cand_col;
  logic [CW-1:0]    low_col;
  logic             on_cand;

  always_comb begin
    low_col = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (ret[i]) low_col = CW'(i);
    end
  end

  assign on_cand = sample && enable && (row == cand_row);
  assign push    = on_cand && (state == KS_PEND) && ret[cand_col];
  assign code    = '{ctrl: ctrl_key, shift: shift_key, row: cand_row, col: cand_col};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= KS_IDLE;
      cand_row <= '0;
      cand_col <= '0;
    end else if (sample) begin
      unique case (state)
        KS_IDLE: if (|ret) begin
          cand_row <= row;
          cand_col <= low_col;
          state    <= KS_PEND;
        end
        KS_PEND: if (row == cand_row) state <= ret[cand_col] ? KS_HELD : KS_IDLE;
        KS_HELD: if (row == cand_row && !ret[cand_col]) state <= KS_IDLE;
        default: state <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kms_fifo.sv
module kms_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wptr, rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign head  = mem[rptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (pop && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/kms_sensor_ram.sv
module kms_sensor_ram #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            sample,
  input  logic [RW-1:0]   row,
  input  logic [COLS-1:0] ret,
  input  logic [RW-1:0]   rd_addr,
  output logic [COLS-1:0] rd_word,
  output logic            changed
);
  logic [COLS-1:0] mem [ROWS];

  assign changed = enable && sample && (mem[row] != ret);
  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (changed) begin
      mem[row] <= ret;
    end
  end
endmodule

// File: rtl/kms_top.sv
module kms_top
  import kms_pkg::*;
#(
  parameter int SCAN_DIV   = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int ROWS      = 1 << ROW_W,
  localparam int COLS      = 1 << COL_W,
  localparam int CODE_W    = $bits(key_code_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sensor,
  input  logic [COLS-1:0]   ret_lines,
  input  logic              shift_key,
  input  logic              ctrl_key,
  output logic [ROW_W-1:0]  scan_row,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] rd_data,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overrun,
  output logic              irq
);
  logic            sample;
  logic            key_push;
  key_code_t       key_code;
  logic [CODE_W-1:0] fifo_head;
  logic [COLS-1:0] sens_word;
  logic            sens_changed;
  logic            sens_flag;
  logic            kbd_pop;

  kms_scan_timer #(.ROWS(ROWS), .SCAN_DIV(SCAN_DIV)) u_timer (
    .clk(clk), .rst(rst), .row(scan_row), .sample(sample)
  );

  kms_key_debounce #(.COLS(COLS)) u_deb (
    .clk(clk), .rst(rst), .enable(!mode_sensor), .sample(sample),
    .row(scan_row), .ret(ret_lines), .shift_key(shift_key),
    .ctrl_key(ctrl_key), .push(key_push), .code(key_code)
  );

  assign kbd_pop = rd_en && !mode_sensor;

  kms_fifo #(.WIDTH(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(key_push), .wdata(key_code),
    .pop(kbd_pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  kms_sensor_ram #(.ROWS(ROWS), .COLS(COLS)) u_sens (
    .clk(clk), .rst(rst), .enable(mode_sensor), .sample(sample),
    .row(scan_row), .ret(ret_lines), .rd_addr(rd_addr),
    .rd_word(sens_word), .changed(sens_changed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      overrun   <= 1'b0;
      sens_flag <= 1'b0;
    end else begin
      if (key_push && fifo_full) overrun <= 1'b1;
      if (sens_changed)          sens_flag <= 1'b1;
      else if (rd_en && mode_sensor) sens_flag <= 1'b0;
      if (rd_en) begin
        if (mode_sensor)      rd_data <= CODE_W'(sens_word);
        else if (!fifo_empty) rd_data <= fifo_head;
      end
    end
  end

  assign irq = mode_sensor ? sens_flag : !fifo_empty;
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int ROW_W  = 3,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_sensor,
  input logic              rd_en,
  input logic [ROW_W-1:0]  scan_row,
  input logic [CODE_W-1:0] rd_data,
  input logic              fifo_empty,
  input logic              fifo_full,
  input logic              overrun
);
  p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
    (scan_row != $past(scan_row)) |-> (scan_row == $past(scan_row) + 1'b1));

  p_no_full_empty_r7: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_full_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !rd_en) |=> fifo_full);

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && rd_en && !mode_sensor) |=> ($stable(rd_data) && fifo_empty));

  p_sensor_no_push_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_sensor && fifo_empty) |=> fifo_empty);
endmodule

bind kms_top kms_checker #(.ROW_W(kms_pkg::ROW_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .mode_sensor(mode_sensor), .rd_en(rd_en),
  .scan_row(scan_row), .rd_data(rd_data), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .overrun(overrun)
);

// File: tb/tb_kms_top.sv
module tb_kms_top;
  localparam int SD   = 4;
  localparam int SCAN = 8 * SD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_sensor = 1'b0;
  logic [7:0] ret_lines;
  logic       shift_key = 1'b0;
  logic       ctrl_key = 1'b0;
  logic [2:0] scan_row;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       fifo_empty, fifo_full, overrun, irq;
  logic [7:0] mat [8];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign ret_lines = mat[scan_row];

  kms_top #(.SCAN_DIV(SD), .FIFO_DEPTH(8)) dut (
    .clk(clk), .rst(rst), .mode_sensor(mode_sensor), .ret_lines(ret_lines),
    .shift_key(shift_key), .ctrl_key(ctrl_key), .scan_row(scan_row),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overrun(overrun), .irq(irq)
  );

  // row[21:19] colmask[18:11] shift[10] ctrl[9] unused[8] expected code[7:0]
  localparam logic [21:0] VEC [6] = '{
    {3'd2, 8'h10, 1'b0, 1'b0, 1'b0, 8'h14},
    {3'd5, 8'h01, 1'b1, 1'b0, 1'b0, 8'h68},
    {3'd7, 8'h80, 1'b0, 1'b1, 1'b0, 8'hBF},
    {3'd0, 8'h28, 1'b1, 1'b1, 1'b0, 8'hC3},
    {3'd3, 8'h40, 1'b0, 1'b0, 1'b0, 8'h1E},
    {3'd6, 8'h06, 1'b0, 1'b1, 1'b0, 8'hB1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_scans(input int n);
    repeat (n * SCAN) @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] a);
    rd_addr = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic press(input logic [2:0] r, input logic [7:0] m);
    mat[r] = m;
    wait_scans(3);
    mat[r] = 8'h00;
    wait_scans(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bad;
    for (int i = 0; i < 8; i++) mat[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", irq, 0);
    chk("R1 row", scan_row, 0);

    // R2 row sequencing
    bad = 0;
    for (int k = 0; k < 2 * SCAN; k++) begin
      if (scan_row !== 3'((k / SD) % 8)) bad++;
      @(negedge clk);
    end
    chk("R2 row sequence mismatches", bad, 0);

    // R3/R6 table of keys, read back in order
    for (int v = 0; v < 6; v++) begin
      shift_key = VEC[v][10];
      ctrl_key  = VEC[v][9];
      press(VEC[v][21:19], VEC[v][18:11]);
    end
    shift_key = 1'b0;
    ctrl_key  = 1'b0;
    chk("R10 irq with data", irq, 1);
    for (int v = 0; v < 6; v++) begin
      host_read(3'd0);
      chk($sformatf("R3 R6 code %0d", v), rd_data, VEC[v][7:0]);
    end
    chk("R6 empty after drain", fifo_empty, 1);
    chk("R10 irq when empty", irq, 0);

    // R8 read on empty
    host_read(3'd0);
    chk("R8 rd_data held", rd_data, 8'hB1);
    chk("R8 still empty", fifo_empty, 1);

    // R4 bounce: closed for one row visit only
    @(negedge clk);
    while (scan_row != 3'd4) @(negedge clk);
    mat[4] = 8'h02;
    while (scan_row != 3'd5) @(negedge clk);
    mat[4] = 8'h00;
    wait_scans(3);
    chk("R4 bounce rejected", fifo_empty, 1);

    // R5 held key once, re-press again
    mat[1] = 8'h08;
    wait_scans(6);
    mat[1] = 8'h00;
    wait_scans(2);
    host_read(3'd0);
    chk("R5 held code", rd_data, 8'h0B);
    chk("R5 single code", fifo_empty, 1);
    press(3'd1, 8'h08);
    chk("R5 re-press pushes", fifo_empty, 0);
    host_read(3'd0);
    chk("R5 re-press code", rd_data, 8'h0B);

    // R7 overflow
    for (int i = 0; i < 8; i++) press(3'(i), 8'h04);
    chk("R7 full", fifo_full, 1);
    chk("R7 no overrun yet", overrun, 0);
    press(3'd0, 8'h80);
    chk("R7 overrun set", overrun, 1);
    for (int i = 0; i < 8; i++) begin
      host_read(3'd0);
      chk($sformatf("R7 kept code %0d", i), rd_data, {2'b00, 3'(i), 3'd2});
    end
    chk("R7 dropped code absent", fifo_empty, 1);
    chk("R7 overrun sticky", overrun, 1);

    // R9/R11 sensor mode
    mode_sensor = 1'b1;
    shift_key = 1'b1;
    ctrl_key  = 1'b1;
    mat[3] = 8'hA5;
    wait_scans(2);
    chk("R11 irq on change", irq, 1);
    host_read(3'd3);
    chk("R9 row data", rd_data, 8'hA5);
    chk("R11 irq cleared by read", irq, 0);
    host_read(3'd2);
    chk("R9 other row zero", rd_data, 8'h00);
    wait_scans(2);
    chk("R11 no re-raise on same data", irq, 0);
    chk("R9 no FIFO push", fifo_empty, 1);
    mat[3] = 8'h3C;
    wait_scans(2);
    chk("R11 irq on second change", irq, 1);
    host_read(3'd3);
    chk("R9 updated row", rd_data, 8'h3C);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule